// File: doc/BRIEF.md
# Ethernet destination address filter

This block watches the bytes of an incoming frame and decides, from the 48-bit destination address alone, whether the frame is for this station. It accepts the frame in four cases. The address is this station's programmed address. The address is the all-ones broadcast address and broadcast reception is enabled. The address is a multicast address whose hash selects a set bit in a 64-bit filter and multicast reception is enabled. Promiscuous mode is on.

While the six address bytes arrive, the block builds a CRC-32 over them. The top six bits of that CRC pick one bit of the hash filter. The filter is imperfect: several group addresses share each bit, and the frame check sequence over the whole frame is left to other logic. A receive path holds the first bytes of a frame until the decision is ready, then either commits or drops the frame. It uses the match type to record what kind of address was matched.

Top module: `eth_da_filter`

## Requirements
- R1: After reset, and until the first decision, `dec_valid`, `dec_accept` and `dec_kind` are all zero.
- R2: A byte is taken only in a cycle where `rx_valid` is high. `rx_sof` marks the first destination byte and has no effect while `rx_valid` is low. Cycles with `rx_valid` low inside the address field stall the count and do not alter the result. `dec_valid` is low up to the edge that takes the sixth destination byte and rises in the cycle after it.
- R3: Once raised, `dec_valid`, `dec_accept` and `dec_kind` hold their values while further non-start bytes arrive. They all go to zero in the cycle after a byte taken with `rx_sof` high.
- R4: The address is a physical match when destination byte k (k = 0 first on the wire) equals `station_addr[8k+7:8k]` for every k from 0 to 5. A physical match is accepted whatever the enables, with `dec_kind` = 2'b01.
- R5: A destination of all 48 ones that is not a physical match is accepted with `dec_kind` = 2'b11 when `cfg_bcast_en` is high. Otherwise it is rejected. Broadcast takes priority over the hash.
- R6: A destination is multicast when bit 0 of byte 0 is one. The CRC is the CRC-32 polynomial 0x04C11DB7, preset to all ones, fed each byte least significant bit first, and shifting toward bit 31 with no final inversion. Its bits [31:26] after the six bytes, read as an unsigned number n, select `mcast_hash[n]`. A multicast destination that is neither physical nor broadcast is accepted with `dec_kind` = 2'b10 only when `cfg_mcast_en` is high and that bit is set.
- R7: A unicast destination (bit 0 of byte 0 zero) that does not match the station address is rejected.
- R8: With `cfg_promisc` high when the sixth byte is taken, every frame is accepted and `dec_kind` reports 2'b01.
- R9: Whenever `dec_accept` is low, `dec_kind` is 2'b00. `dec_accept` is never high while `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte strobe for `rx_data` |
| rx_sof | input | 1 | First byte of a frame, qualified by `rx_valid` |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Station address, byte k on wire at bits [8k+7:8k] |
| mcast_hash | input | 64 | Multicast hash filter bits |
| cfg_bcast_en | input | 1 | Accept broadcast frames |
| cfg_mcast_en | input | 1 | Accept multicast frames that hit the hash |
| cfg_promisc | input | 1 | Accept every frame |
| dec_valid | output | 1 | Decision available for the current frame |
| dec_accept | output | 1 | Frame accepted |
| dec_kind | output | 2 | 00 none, 01 physical, 10 multicast, 11 broadcast |

## Verification
A corrupted CRC register shows only on multicast frames that are not broadcast. It appears as an accept or reject flipped against a single-bit hash filter one cycle after the sixth byte, so the bench sets one filter bit at a time and checks both the selected bit and its complement. A wrong byte counter shows as `dec_valid` rising a cycle early or late, or as trailing bytes changing a held decision. Stale running match flags show on the frame after a broadcast or station-match frame, when a miss would be wrongly accepted.

// File: rtl/eth_da_filter.sv
module eth_da_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic [7:0]              rx_data,
  input  logic [8*ADDR_BYTES-1:0] station_addr,
  input  logic [(1<<HASH_BITS)-1:0] mcast_hash,
  input  logic                    cfg_bcast_en,
  input  logic                    cfg_mcast_en,
  input  logic                    cfg_promisc,
  output logic                    dec_valid,
  output logic                    dec_accept,
  output logic [1:0]              dec_kind
);

  localparam int          CW    = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] DONE = CW'(ADDR_BYTES);
  localparam logic [31:0] POLY  = 32'h04C11DB7;
  localparam logic [1:0]  K_NONE = 2'b00, K_PHYS = 2'b01, K_MCAST = 2'b10, K_BCAST = 2'b11;

  logic [CW-1:0] cnt;
  logic          phys_q, bc_q, mc_q;
  logic [31:0]   crc_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  wire            take     = rx_valid && (rx_sof || cnt < DONE);
  wire [CW-1:0]   idx      = rx_sof ? '0 : cnt;
  wire [7:0]      sta_b    = station_addr[idx*8 +: 8];
  wire [31:0]     crc_nx   = crc_step(rx_sof ? 32'hFFFF_FFFF : crc_q, rx_data);
  wire            phys_nx  = (rx_sof | phys_q) & (rx_data == sta_b);
  wire            bc_nx    = (rx_sof | bc_q) & (&rx_data);
  wire            mc_nx    = rx_sof ? rx_data[0] : mc_q;
  wire            hash_hit = mcast_hash[crc_nx[31:32-HASH_BITS]];

  logic       acc_nx;
  logic [1:0] kind_nx;

  always_comb begin
    acc_nx  = 1'b0;
    kind_nx = K_NONE;
    if (cfg_promisc || phys_nx) begin
      acc_nx  = 1'b1;
      kind_nx = K_PHYS;
    end else if (bc_nx) begin
      if (cfg_bcast_en) begin
        acc_nx  = 1'b1;
        kind_nx = K_BCAST;
      end
    end else if (mc_nx) begin
      if (cfg_mcast_en && hash_hit) begin
        acc_nx  = 1'b1;
        kind_nx = K_MCAST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= DONE;
      crc_q      <= '1;
      phys_q     <= 1'b0;
      bc_q       <= 1'b0;
      mc_q       <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_kind   <= K_NONE;
    end else if (take) begin
      cnt    <= idx + 1'b1;
      crc_q  <= crc_nx;
      phys_q <= phys_nx;
      bc_q   <= bc_nx;
      mc_q   <= mc_nx;
      if (rx_sof) begin
        dec_valid  <= 1'b0;
        dec_accept <= 1'b0;
        dec_kind   <= K_NONE;
      end
      if (idx == LAST) begin
        dec_valid  <= 1'b1;
        dec_accept <= acc_nx;
        dec_kind   <= kind_nx;
      end
    end
  end

  p_accept_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);

  p_reject_has_no_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_accept |-> dec_kind == K_NONE);

  p_hold_decision_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !(rx_valid && rx_sof) |=> dec_valid && $stable(dec_accept) && $stable(dec_kind));

  p_sof_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_sof |=> !dec_valid);

  p_rise_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) |-> $past(rx_valid) && !$past(rx_sof));

  p_promisc_accepts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && $past(cfg_promisc) |-> dec_accept && dec_kind == K_PHYS);

  p_unicast_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_valid) && !$past(cfg_promisc) && !mc_q |-> dec_kind == K_NONE || dec_kind == K_PHYS);

endmodule

// File: tb/sim_eth_da_filter.sv
module sim_eth_da_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [47:0] station_addr = '0;
  logic [63:0] mcast_hash = '0;
  logic        cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0, cfg_promisc = 1'b0;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_kind;

  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  eth_da_filter u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .station_addr(station_addr), .mcast_hash(mcast_hash), .cfg_bcast_en(cfg_bcast_en),
    .cfg_mcast_en(cfg_mcast_en), .cfg_promisc(cfg_promisc),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_kind(dec_kind));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      logic fb = c[31] ^ da[k];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c[31:26];
  endfunction

  function automatic logic [2:0] expect_dec(input logic [47:0] da);
    if (cfg_promisc) return 3'b101;
    if (da == station_addr) return 3'b101;
    if (&da) return cfg_bcast_en ? 3'b111 : 3'b000;
    if (da[0]) return (cfg_mcast_en && mcast_hash[hidx(da)]) ? 3'b110 : 3'b000;
    return 3'b000;
  endfunction

  task automatic idle;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic frame(input string tag, input logic [47:0] da, input bit gaps);
    logic [2:0] e;
    e = expect_dec(da);
    for (int i = 0; i < 6; i++) begin
      if (gaps && ($urandom % 3 == 0)) idle();
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = da[8*i +: 8];
      if (i == 5) chk({tag, " R2 early"}, dec_valid, 0);
    end
    idle();
    chk({tag, " R2 valid"}, dec_valid, 1);
    chk({tag, " accept"}, dec_accept, e[1:0] != 0 ? 1 : 0);
    chk({tag, " kind"}, dec_kind, e[1:0]);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'($urandom);
    end
    idle();
    chk({tag, " R3 hold"}, {dec_valid, dec_accept, dec_kind}, {1'b1, e[1:0] != 0, e[1:0]});
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [47:0] da;
    logic [5:0]  h;
    void'($urandom(32'h5EED_0042));
    station_addr = 48'h66_55_44_33_22_10;
    repeat (3) @(negedge clk);
    chk("R1 reset", {dec_valid, dec_accept, dec_kind}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rx_sof = 1'b1; rx_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle", {dec_valid, dec_accept, dec_kind}, 0);
    rx_sof = 1'b0;

    frame("R4 station", station_addr, 0);
    frame("R7 miss", 48'h66_55_44_33_22_12, 0);
    frame("R5 bcast off", '1, 0);
    cfg_bcast_en = 1; frame("R5 bcast on", '1, 1);
    @(negedge clk); rx_valid = 1; rx_sof = 1; rx_data = 8'h01;
    @(negedge clk); rx_sof = 0;
    chk("R3 sof clears", {dec_valid, dec_accept, dec_kind}, 0);
    idle();

    da = 48'hAB_CD_EF_01_00_5E;
    da[0] = 1'b1;
    h = hidx(da);
    cfg_mcast_en = 1; mcast_hash = 64'd1 << h;
    frame("R6 hash bit", da, 1);
    mcast_hash = ~(64'd1 << h);
    frame("R6 other bits", da, 1);
    mcast_hash = '1; cfg_mcast_en = 0;
    frame("R6 mcast off", da, 0);
    cfg_mcast_en = 1;
    frame("R6 all bits", da, 0);
    frame("R5 bcast over hash", '1, 0);

    station_addr = 48'h11_22_33_44_55_07;
    cfg_mcast_en = 0; cfg_bcast_en = 0;
    frame("R4 mcast station", station_addr, 0);
    station_addr = 48'h66_55_44_33_22_10;
    cfg_promisc = 1;
    frame("R8 promisc miss", 48'h01_02_03_04_05_06, 1);
    frame("R8 promisc bcast", '1, 0);
    cfg_promisc = 0;
    frame("R7 after promisc", 48'h01_02_03_04_05_06, 0);

    for (int n = 0; n < 300; n++) begin
      case ($urandom % 5)
        0: da = station_addr;
        1: da = '1;
        2: begin da = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE; end
        default: begin da = {$urandom, $urandom}; da[0] = 1'b1; end
      endcase
      mcast_hash   = {$urandom, $urandom};
      cfg_bcast_en = 1'($urandom);
      cfg_mcast_en = 1'($urandom);
      cfg_promisc  = ($urandom % 8 == 0);
      frame("R9 random", da, 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule